// File: doc/BRIEF.md
# Video Automatic Gain Controller

This block closes the gain loop of a video front end. Once per video line, a measurement stage reports four amplitudes: sync tip height, colour burst amplitude, composite peak and luma peak. It also reports a flag that is set when the converter clipped during that line. The controller compares each enabled amplitude with its own target. From that comparison it moves a front-end gain word and a separate back-end compensation gain.

The front-end gain word is 16 bits wide. Its upper four bits are the coarse amplifier code and its lower twelve bits are the fine gain code. Gain is cut at once when the line is too strong or clipped. Gain rises only after a programmable run of quiet lines, and by a step whose size is programmable. The back-end gain moves by one count per line. It ignores the composite peak, so it can recover overall gain that a strong composite peak took away at the front end. When automatic control is off, the gain follows manual register values.

Top module: `video_agc`

## Requirements
- R1: After reset the coarse code is 8, the fine code is 0 and the back-end gain is 128. The readback equals 0x8000 while automatic control is enabled.
- R2: On a line strobe with automatic control enabled, the 16-bit gain word {coarse, fine} drops by 4096 (one coarse step), with a floor of 0. This happens if the clip flag is set, or if any front-end-enabled reference measures strictly above its target. Mask bit 0 is sync height, bit 1 is burst, bit 2 is composite peak and bit 3 is luma peak.
- R3: The gain word rises by 2^incSpeed, with a ceiling of 0xFFFF, only on a strobe that meets all three conditions: there is no over-target or clip condition, every front-end-enabled reference is strictly below target, and at least incDelay consecutive strobes with no over-target or clip condition came just before it. An over-target or clip strobe restarts that count.
- R4: The fine code carries into the coarse code on increase. For example, coarse 3 with fine 0xFF8, plus 16, gives coarse 4 with fine 0x008.
- R5: A strobe holds the front-end gain unchanged in either of two cases: an enabled reference equals its target and none is above it, or no front-end reference is enabled and clip is clear.
- R6: The back-end gain falls by 1 on a strobe where any back-end-enabled reference is above target. It rises by 1 when every enabled one is below target. It stays within 64..255, and the clip flag does not affect it.
- R7: Bit 2 (composite peak) of the back-end mask is ignored. With only that bit set, the back-end gain holds.
- R8: While automatic control is disabled, the outputs show the manual coarse and fine values and a back-end gain of 128 one clock later. The quiet-line count is cleared, and the loop resumes from the manual value.
- R9: The readback output equals the gain word while automatic control is enabled and reads 0 while it is disabled.
- R10: Gains change only at the clock edge that samples a line strobe. The new value is visible in the next cycle and holds between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStrobe | input | 1 | One-cycle pulse: this line's measurements are valid |
| agcEn | input | 1 | 1 = automatic control, 0 = manual gain |
| clipFlag | input | 1 | Converter clipped during this line |
| syncLevel | input | 10 | Measured sync height |
| burstLevel | input | 10 | Measured burst amplitude |
| compPeakLevel | input | 10 | Measured composite peak |
| lumaPeakLevel | input | 10 | Measured luma peak |
| syncTarget | input | 10 | Target for sync height |
| burstTarget | input | 10 | Target for burst amplitude |
| compPeakTarget | input | 10 | Target for composite peak |
| lumaPeakTarget | input | 10 | Target for luma peak |
| feRefEn | input | 4 | Front-end reference mask |
| beRefEn | input | 4 | Back-end reference mask (bit 2 ignored) |
| incSpeed | input | 4 | Increase step exponent |
| incDelay | input | 8 | Quiet strobes required before an increase |
| manCoarse | input | 4 | Manual coarse code |
| manFine | input | 12 | Manual fine code |
| coarseGain | output | 4 | Coarse amplifier code |
| fineGain | output | 12 | Fine gain code |
| curGain | output | 16 | Gain readback |
| beGain | output | 8 | Back-end compensation gain |

## Verification
A wrong quiet-line count in the controller shows up at the ports as a gain rise that comes one or more lines too early or too late after a clip or an over-target line. Each strobe's result is compared in the cycle after that strobe, so such an error is caught on the first wrongly timed line. A wrong carry or saturation in the gain word shows up as a wrong coarse code on the same line. A back-end mask fault shows up as a back-end gain that moves when composite peak alone is enabled.

// File: rtl/agc_pkg.sv
package agc_pkg;
  localparam int NUM_REF   = 4;
  localparam int REF_SYNC  = 0;
  localparam int REF_BURST = 1;
  localparam int REF_CPEAK = 2;
  localparam int REF_LPEAK = 3;

  // back-end loop cannot see the composite peak
  localparam logic [NUM_REF-1:0] BE_EXCLUDE = NUM_REF'(1) << REF_CPEAK;

  typedef struct packed {
    logic feUp;
    logic feDown;
    logic beUp;
    logic beDown;
    logic manual;
  } agc_strobe_t;
endpackage

// File: rtl/agc_ctrl.sv
module agc_ctrl
  import agc_pkg::*;
#(
  parameter int MEAS_W = 10,
  parameter int DLY_W  = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            lineStrobe,
  input  logic                            agcEn,
  input  logic                            clipFlag,
  input  logic [NUM_REF-1:0][MEAS_W-1:0]  refLevel,
  input  logic [NUM_REF-1:0][MEAS_W-1:0]  refTarget,
  input  logic [NUM_REF-1:0]              feRefEn,
  input  logic [NUM_REF-1:0]              beRefEn,
  input  logic [DLY_W-1:0]                incDelay,
  output agc_strobe_t                     strobes
);
  localparam logic [DLY_W-1:0] QUIET_MAX = '1;

  logic [NUM_REF-1:0] aboveTgt;
  logic [NUM_REF-1:0] belowTgt;
  logic [NUM_REF-1:0] beMask;
  logic [DLY_W-1:0]   quietCnt;
  logic feOver, feAllUnder, beOver, beAllUnder, active, delayMet;

  for (genvar i = 0; i < NUM_REF; i++) begin : g_cmp
    assign aboveTgt[i] = refLevel[i] > refTarget[i];
    assign belowTgt[i] = refLevel[i] < refTarget[i];
  end

  assign beMask     = beRefEn & ~BE_EXCLUDE;
  assign feOver     = clipFlag | (|(aboveTgt & feRefEn));
  assign feAllUnder = (|feRefEn) & (&(belowTgt | ~feRefEn));
  assign beOver     = |(aboveTgt & beMask);
  assign beAllUnder = (|beMask) & (&(belowTgt | ~beMask));
  assign active     = lineStrobe & agcEn;
  assign delayMet   = quietCnt >= incDelay;

  // consecutive strobes without an over-target or clip condition
  always_ff @(posedge clk) begin
    if (!rstN || !agcEn) begin
      quietCnt <= '0;
    end else if (lineStrobe) begin
      if (feOver)                   quietCnt <= '0;
      else if (quietCnt != QUIET_MAX) quietCnt <= quietCnt + DLY_W'(1);
    end
  end

  always_comb begin
    strobes        = '0;
    strobes.manual = !agcEn;
    strobes.feDown = active & feOver;
    strobes.feUp   = active & !feOver & feAllUnder & delayMet;
    strobes.beDown = active & beOver;
    strobes.beUp   = active & !beOver & beAllUnder;
  end
endmodule

// File: rtl/agc_datapath.sv
module agc_datapath
  import agc_pkg::*;
#(
  parameter int COARSE_W     = 4,
  parameter int FINE_W       = 12,
  parameter int SPEED_W      = 4,
  parameter int BE_W         = 8,
  parameter int BE_MIN       = 64,
  parameter int BE_MAX       = 255,
  parameter int BE_UNITY     = 128,
  parameter int RESET_COARSE = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  agc_strobe_t                  strobes,
  input  logic [SPEED_W-1:0]           incSpeed,
  input  logic [COARSE_W-1:0]          manCoarse,
  input  logic [FINE_W-1:0]            manFine,
  output logic [COARSE_W+FINE_W-1:0]   gainWord,
  output logic [BE_W-1:0]              beGain
);
  localparam int GAIN_W = COARSE_W + FINE_W;
  localparam logic [GAIN_W-1:0] GAIN_MAX    = '1;
  localparam logic [GAIN_W-1:0] COARSE_STEP = GAIN_W'(1) << FINE_W;
  localparam logic [GAIN_W-1:0] RESET_WORD  = GAIN_W'(RESET_COARSE) << FINE_W;
  localparam logic [BE_W-1:0]   BE_LO  = BE_W'(BE_MIN);
  localparam logic [BE_W-1:0]   BE_HI  = BE_W'(BE_MAX);
  localparam logic [BE_W-1:0]   BE_ONE = BE_W'(BE_UNITY);

  logic [GAIN_W-1:0] gainQ;
  logic [GAIN_W-1:0] upStep;
  logic [BE_W-1:0]   beQ;

  assign upStep = GAIN_W'(1) << incSpeed;

  // coarse and fine form one word, so carries and borrows cross naturally
  always_ff @(posedge clk) begin
    if (!rstN)                 gainQ <= RESET_WORD;
    else if (strobes.manual)   gainQ <= {manCoarse, manFine};
    else if (strobes.feDown)   gainQ <= (gainQ < COARSE_STEP) ? '0 : gainQ - COARSE_STEP;
    else if (strobes.feUp)     gainQ <= (gainQ > GAIN_MAX - upStep) ? GAIN_MAX : gainQ + upStep;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.manual) beQ <= BE_ONE;
    else if (strobes.beDown)     beQ <= (beQ > BE_LO) ? beQ - BE_W'(1) : BE_LO;
    else if (strobes.beUp)       beQ <= (beQ < BE_HI) ? beQ + BE_W'(1) : BE_HI;
  end

  assign gainWord = gainQ;
  assign beGain   = beQ;
endmodule

// File: rtl/video_agc.sv
module video_agc
  import agc_pkg::*;
#(
  parameter int MEAS_W       = 10,
  parameter int COARSE_W     = 4,
  parameter int FINE_W       = 12,
  parameter int SPEED_W      = 4,
  parameter int DLY_W        = 8,
  parameter int BE_W         = 8,
  parameter int BE_MIN       = 64,
  parameter int BE_MAX       = 255,
  parameter int BE_UNITY     = 128,
  parameter int RESET_COARSE = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         lineStrobe,
  input  logic                         agcEn,
  input  logic                         clipFlag,
  input  logic [MEAS_W-1:0]            syncLevel,
  input  logic [MEAS_W-1:0]            burstLevel,
  input  logic [MEAS_W-1:0]            compPeakLevel,
  input  logic [MEAS_W-1:0]            lumaPeakLevel,
  input  logic [MEAS_W-1:0]            syncTarget,
  input  logic [MEAS_W-1:0]            burstTarget,
  input  logic [MEAS_W-1:0]            compPeakTarget,
  input  logic [MEAS_W-1:0]            lumaPeakTarget,
  input  logic [3:0]                   feRefEn,
  input  logic [3:0]                   beRefEn,
  input  logic [SPEED_W-1:0]           incSpeed,
  input  logic [DLY_W-1:0]             incDelay,
  input  logic [COARSE_W-1:0]          manCoarse,
  input  logic [FINE_W-1:0]            manFine,
  output logic [COARSE_W-1:0]          coarseGain,
  output logic [FINE_W-1:0]            fineGain,
  output logic [COARSE_W+FINE_W-1:0]   curGain,
  output logic [BE_W-1:0]              beGain
);
  localparam int GAIN_W = COARSE_W + FINE_W;

  logic [NUM_REF-1:0][MEAS_W-1:0] refLevel;
  logic [NUM_REF-1:0][MEAS_W-1:0] refTarget;
  logic [GAIN_W-1:0]              gainWord;
  agc_strobe_t                    strobes;

  // index order: sync, burst, composite peak, luma peak
  assign refLevel  = {lumaPeakLevel, compPeakLevel, burstLevel, syncLevel};
  assign refTarget = {lumaPeakTarget, compPeakTarget, burstTarget, syncTarget};

  agc_ctrl #(.MEAS_W(MEAS_W), .DLY_W(DLY_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .lineStrobe(lineStrobe), .agcEn(agcEn),
    .clipFlag(clipFlag), .refLevel(refLevel), .refTarget(refTarget),
    .feRefEn(feRefEn), .beRefEn(beRefEn), .incDelay(incDelay),
    .strobes(strobes)
  );

  agc_datapath #(
    .COARSE_W(COARSE_W), .FINE_W(FINE_W), .SPEED_W(SPEED_W), .BE_W(BE_W),
    .BE_MIN(BE_MIN), .BE_MAX(BE_MAX), .BE_UNITY(BE_UNITY),
    .RESET_COARSE(RESET_COARSE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .incSpeed(incSpeed),
    .manCoarse(manCoarse), .manFine(manFine),
    .gainWord(gainWord), .beGain(beGain)
  );

  assign coarseGain = gainWord[GAIN_W-1:FINE_W];
  assign fineGain   = gainWord[FINE_W-1:0];
  assign curGain    = agcEn ? gainWord : '0;
endmodule

// File: rtl/video_agc_chk.sv
module video_agc_chk #(
  parameter int COARSE_W = 4,
  parameter int FINE_W   = 12,
  parameter int SPEED_W  = 4,
  parameter int BE_W     = 8,
  parameter int BE_MIN   = 64,
  parameter int BE_MAX   = 255
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       lineStrobe,
  input logic                       agcEn,
  input logic                       clipFlag,
  input logic [SPEED_W-1:0]         incSpeed,
  input logic [COARSE_W-1:0]        manCoarse,
  input logic [FINE_W-1:0]          manFine,
  input logic [COARSE_W-1:0]        coarseGain,
  input logic [FINE_W-1:0]          fineGain,
  input logic [COARSE_W+FINE_W-1:0] curGain,
  input logic [BE_W-1:0]            beGain
);
  localparam int GAIN_W = COARSE_W + FINE_W;
  logic [GAIN_W-1:0] gainNow;
  logic [GAIN_W:0]   gainWide;
  assign gainNow  = {coarseGain, fineGain};
  assign gainWide = {1'b0, gainNow};

  AST_CLIP_LOWERS: assert property (@(posedge clk) disable iff (!rstN)
    (lineStrobe && agcEn && clipFlag && gainNow != '0) |=> (gainNow < $past(gainNow))); // R2

  AST_RISE_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    agcEn |=> (gainWide <= $past(gainWide) + ((GAIN_W+1)'(1) << $past(incSpeed)))); // R3

  AST_MANUAL_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    !agcEn |=> (gainNow == $past({manCoarse, manFine}))); // R8

  AST_READBACK_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !agcEn |-> (curGain == '0)); // R9

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (agcEn && !lineStrobe) |=> ($stable(gainNow) && $stable(beGain))); // R10

  AST_BE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (beGain >= BE_W'(BE_MIN)) && (beGain <= BE_W'(BE_MAX))); // R6
endmodule

bind video_agc video_agc_chk #(
  .COARSE_W(COARSE_W), .FINE_W(FINE_W), .SPEED_W(SPEED_W), .BE_W(BE_W),
  .BE_MIN(BE_MIN), .BE_MAX(BE_MAX)
) u_chk (
  .clk(clk), .rstN(rstN), .lineStrobe(lineStrobe), .agcEn(agcEn),
  .clipFlag(clipFlag), .incSpeed(incSpeed), .manCoarse(manCoarse),
  .manFine(manFine), .coarseGain(coarseGain), .fineGain(fineGain),
  .curGain(curGain), .beGain(beGain)
);

// File: tb/video_agc_bench.sv
`timescale 1ns/1ps
module video_agc_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineStrobe = 1'b0;
  logic agcEn = 1'b1;
  logic clipFlag = 1'b0;
  logic [9:0] syncLevel = '0, burstLevel = '0, compPeakLevel = '0, lumaPeakLevel = '0;
  logic [9:0] syncTarget = 10'd200, burstTarget = 10'd200;
  logic [9:0] compPeakTarget = 10'd800, lumaPeakTarget = 10'd700;
  logic [3:0] feRefEn = 4'b0001, beRefEn = 4'b0000;
  logic [3:0] incSpeed = 4'd4;
  logic [7:0] incDelay = 8'd2;
  logic [3:0] manCoarse = '0;
  logic [11:0] manFine = '0;
  logic [3:0] coarseGain;
  logic [11:0] fineGain;
  logic [15:0] curGain;
  logic [7:0] beGain;

  always #2 clk = ~clk;

  video_agc u_video_agc (
    .clk(clk), .rstN(rstN), .lineStrobe(lineStrobe), .agcEn(agcEn),
    .clipFlag(clipFlag), .syncLevel(syncLevel), .burstLevel(burstLevel),
    .compPeakLevel(compPeakLevel), .lumaPeakLevel(lumaPeakLevel),
    .syncTarget(syncTarget), .burstTarget(burstTarget),
    .compPeakTarget(compPeakTarget), .lumaPeakTarget(lumaPeakTarget),
    .feRefEn(feRefEn), .beRefEn(beRefEn), .incSpeed(incSpeed),
    .incDelay(incDelay), .manCoarse(manCoarse), .manFine(manFine),
    .coarseGain(coarseGain), .fineGain(fineGain), .curGain(curGain),
    .beGain(beGain)
  );

  typedef struct { int gain; int be; int cur; string tag; } exp_t;
  exp_t expQ[$];
  int checks = 0;
  int fails = 0;
  int mGain = 32'h8000;
  int mBe = 128;
  int mQuiet = 0;
  logic sawStrobe = 1'b0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // reference model of one line, written from the requirements
  task automatic modelLine();
    int lv[4];
    int tg[4];
    bit over;
    bit allUnder;
    bit bOver;
    bit bUnder;
    logic [3:0] bm;
    lv = '{int'(syncLevel), int'(burstLevel), int'(compPeakLevel), int'(lumaPeakLevel)};
    tg = '{int'(syncTarget), int'(burstTarget), int'(compPeakTarget), int'(lumaPeakTarget)};
    if (!agcEn) begin
      mGain = {manCoarse, manFine};
      mBe = 128;
      mQuiet = 0;
      return;
    end
    over = clipFlag;
    allUnder = (feRefEn != 0);
    for (int i = 0; i < 4; i++) if (feRefEn[i]) begin
      if (lv[i] > tg[i]) over = 1;
      if (!(lv[i] < tg[i])) allUnder = 0;
    end
    if (over) begin
      mGain = (mGain < 4096) ? 0 : mGain - 4096;
      mQuiet = 0;
    end else begin
      if (allUnder && mQuiet >= int'(incDelay))
        mGain = (mGain + (1 << incSpeed) > 65535) ? 65535 : mGain + (1 << incSpeed);
      if (mQuiet < 255) mQuiet++;
    end
    bm = beRefEn & 4'b1011;
    bOver = 0;
    bUnder = (bm != 0);
    for (int i = 0; i < 4; i++) if (bm[i]) begin
      if (lv[i] > tg[i]) bOver = 1;
      if (!(lv[i] < tg[i])) bUnder = 0;
    end
    if (bOver) mBe = (mBe > 64) ? mBe - 1 : 64;
    else if (bUnder) mBe = (mBe < 255) ? mBe + 1 : 255;
  endtask

  // driver: one line strobe, pushes the expected result
  task automatic doLine(input string tag, input int s, input int b, input int c,
                        input int l, input bit clip);
    exp_t e;
    @(negedge clk);
    syncLevel = 10'(s); burstLevel = 10'(b);
    compPeakLevel = 10'(c); lumaPeakLevel = 10'(l);
    clipFlag = clip;
    lineStrobe = 1'b1;
    modelLine();
    e.gain = mGain; e.be = mBe; e.cur = agcEn ? mGain : 0; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    lineStrobe = 1'b0;
    clipFlag = 1'b0;
  endtask

  task automatic setManual(input int c, input int f);
    @(negedge clk);
    agcEn = 1'b0; manCoarse = 4'(c); manFine = 12'(f);
    doLine("R8", 0, 0, 0, 0, 0);
    @(negedge clk);
    agcEn = 1'b1;
  endtask

  // monitor
  always @(posedge clk) sawStrobe <= lineStrobe;
  always @(negedge clk) begin
    if (sawStrobe) begin
      if (expQ.size() == 0) begin
        check("R10", "unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(e.tag, "gain word", int'({coarseGain, fineGain}), e.gain);
        check(e.tag, "back-end gain", int'(beGain), e.be);
        check("R9", "readback", int'(curGain), e.cur);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check("R10", "watchdog expired", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "reset coarse", int'(coarseGain), 8);
    check("R1", "reset fine", int'(fineGain), 0);
    check("R1", "reset back-end", int'(beGain), 128);
    check("R1", "reset readback", int'(curGain), 32'h8000);

    // R3: increase only on the third quiet line with incDelay 2
    for (int i = 0; i < 4; i++) doLine("R3", 100, 0, 0, 0, 0);
    @(negedge clk);
    check("R3", "after delay", int'({coarseGain, fineGain}), 32'h8020);
    // R2: clip cuts at once, then the delay restarts
    doLine("R2", 100, 0, 0, 0, 1);
    for (int i = 0; i < 3; i++) doLine("R3", 100, 0, 0, 0, 0);
    doLine("R2", 300, 0, 0, 0, 0);
    // R10: hold between strobes
    repeat (3) @(negedge clk);
    check("R10", "hold idle", int'({coarseGain, fineGain}), mGain);
    // R5: equal to target, and no reference enabled
    for (int i = 0; i < 4; i++) doLine("R5", 200, 0, 0, 0, 0);
    feRefEn = 4'b0000;
    for (int i = 0; i < 4; i++) doLine("R5", 100, 0, 0, 0, 0);
    // R2: one reference over among several
    feRefEn = 4'b1001;
    doLine("R2", 100, 0, 0, 900, 0);
    feRefEn = 4'b0110;
    doLine("R2", 0, 100, 900, 0, 0);
    for (int i = 0; i < 4; i++) doLine("R3", 0, 100, 500, 0, 0);

    // R4: carry from fine into coarse
    feRefEn = 4'b0001; incDelay = 8'd0; incSpeed = 4'd4;
    setManual(3, 12'hFF8);
    doLine("R4", 100, 0, 0, 0, 0);
    @(negedge clk);
    check("R4", "carry coarse", int'(coarseGain), 4);
    check("R4", "carry fine", int'(fineGain), 8);
    // R3 ceiling
    incSpeed = 4'd15;
    setManual(15, 12'hFF0);
    doLine("R3", 100, 0, 0, 0, 0);
    @(negedge clk);
    check("R3", "ceiling", int'({coarseGain, fineGain}), 32'hFFFF);
    // R2 floor
    incSpeed = 4'd4;
    setManual(0, 12'h800);
    doLine("R2", 300, 0, 0, 0, 0);
    @(negedge clk);
    check("R2", "floor", int'({coarseGain, fineGain}), 0);

    // R6: back-end loop on luma peak
    beRefEn = 4'b1000;
    for (int i = 0; i < 130; i++) doLine("R6", 100, 0, 0, 600, 0);
    @(negedge clk);
    check("R6", "back-end ceiling", int'(beGain), 255);
    doLine("R6", 100, 0, 0, 900, 0);
    doLine("R6", 100, 0, 0, 600, 1);
    // R7: composite peak bit ignored by the back end
    beRefEn = 4'b0100;
    doLine("R7", 100, 0, 900, 0, 0);
    doLine("R7", 100, 0, 100, 0, 0);
    @(negedge clk);
    check("R7", "comp bit ignored", int'(beGain), 255);
    beRefEn = 4'b1010;
    for (int i = 0; i < 200; i++) doLine("R6", 100, 300, 0, 900, 0);
    @(negedge clk);
    check("R6", "back-end floor", int'(beGain), 64);

    // R8/R9: manual mode output and readback
    setManual(6, 12'h123);
    @(negedge clk);
    agcEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R8", "manual coarse", int'(coarseGain), 6);
    check("R9", "readback off", int'(curGain), 0);
    check("R8", "manual back-end", int'(beGain), 128);
    agcEn = 1'b1;

    repeat (4) @(negedge clk);
    check("R10", "queue drained", expQ.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule